// File: doc/BRIEF.md
# Multichannel Slot Enable Controller

This block decides, slot by slot, whether a word position in a serial frame is live. A frame carries up to 128 word slots (channels), grouped into eight blocks of sixteen consecutive channels. Two blocks are active at a time, called A and B. Each has a three-bit block number and a sixteen-bit enable mask, packed together into one 32-bit mask word. The controller counts word strobes from the frame sync and works out the channel number. For each slot it raises an enable when the channel lies in an active block and its mask bit is set. A receive path drops the data of slots that are not enabled. A transmit path uses the same enable to drive or release its data line.

The mask and the two block numbers are captured into active copies at each block boundary. Software may therefore rewrite them at any time, and a change takes effect only from the start of the next sixteen-channel group. A one-cycle end-of-block pulse marks the close of every group of sixteen channels, which gives software its cue to load the selects and mask for the next block pair. A run of strobes past channel 127 without a new frame sync takes the frame out of service until the next sync.

Top module: `chan_window_ctrl`

## Requirements
- R1: A word strobe that arrives with frame sync high starts slot channel 0 and sets frame_live. Each later strobe without frame sync, in a live frame, advances cur_chan by one.
- R2: Frame sync is acted on only in a cycle where word strobe is also high. A frame sync pulse on its own changes no output.
- R3: A channel's block number is cur_chan[6:4] and its index within the block is cur_chan[3:0]. If the block equals the active block A select, slot_en is en_mask bit [index]. If it equals the active block B select, slot_en is en_mask bit [16+index].
- R4: A channel whose block equals neither active select has slot_en low, although it still occupies its slot.
- R5: When the A and B selects name the same block, the A half of the mask (bits 15..0) decides the enable.
- R6: blk_a_sel, blk_b_sel and en_mask are captured only on a strobe that starts a slot with index 0 in a live frame. Changes at any other time have no effect until the next such strobe.
- R7: blk_end is high for exactly one cycle, the cycle after a strobe that ends a slot with index 15 in a live frame.
- R8: A strobe without frame sync while on channel 127 clears frame_live. From then until the next strobe with frame sync, slot_en stays low and blk_end stays low.
- R9: All outputs change only in the cycle after a word strobe. Between strobes, slot_en, cur_chan and frame_live hold their values and blk_end is low.
- R10: After reset, cur_chan is 0 and frame_live, slot_en and blk_end are low. Strobes before the first frame sync enable no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_strobe | input | 1 | One-cycle pulse at the start of each word slot |
| frame_sync | input | 1 | Marks the strobed slot as channel 0 of a new frame |
| blk_a_sel | input | 3 | Block number for mask half A |
| blk_b_sel | input | 3 | Block number for mask half B |
| en_mask | input | 32 | Enable bits: 15..0 for block A, 31..16 for block B |
| cur_chan | output | 7 | Channel number of the current slot |
| frame_live | output | 1 | The current slot lies inside a counted frame |
| slot_en | output | 1 | The current slot is enabled |
| blk_end | output | 1 | Pulse after the last slot of a sixteen-channel group |

## Verification
Several properties are checked on every cycle. These are the channel restart on a synced strobe and the single-step advance, and that all outputs hold between strobes. They also cover the origin and width of the end-of-block pulse, that no slot is enabled outside a live frame, and that the active selects and mask stay frozen except on a strobe that opens a block. The bench scenarios are needed to show that the right mask bit is chosen for a given channel, including the case where both selects name the same block. They also show that a rewrite in the middle of a block takes effect only at the next group, and that a frame recovers after running past channel 127. Those scenarios compare every slot against a bench model of the mask lookup.

// File: rtl/cwc_pkg.sv
package cwc_pkg;

    // Which active half, if any, owns the channel of the current slot.
    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_A    = 2'd1,
        HIT_B    = 2'd2
    } hit_e;

    // Half A has priority when both selects name the same block.
    function automatic hit_e pick_hit(input logic a_match, input logic b_match);
        if (a_match) begin
            return HIT_A;
        end
        if (b_match) begin
            return HIT_B;
        end
        return HIT_NONE;
    endfunction

endpackage

// File: rtl/cwc_slot_counter.sv
module cwc_slot_counter #(
    parameter int unsigned CH_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            word_strobe,
    input  logic            frame_sync,
    output logic [CH_W-1:0] chan_q,
    output logic            live_q,
    output logic [CH_W-1:0] nxt_chan,
    output logic            nxt_live
);

    localparam logic [CH_W-1:0] LAST_CH = '1;

    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            live;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (word_strobe) begin
            if (frame_sync) begin
                cnt_d.chan = '0;
                cnt_d.live = 1'b1;
            end else if (cnt_q.live) begin
                if (cnt_q.chan == LAST_CH) begin
                    cnt_d.live = 1'b0;
                end else begin
                    cnt_d.chan = cnt_q.chan + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign chan_q   = cnt_q.chan;
    assign live_q   = cnt_q.live;
    assign nxt_chan = cnt_d.chan;
    assign nxt_live = cnt_d.live;

endmodule

// File: rtl/cwc_mask_bank.sv
module cwc_mask_bank #(
    parameter int unsigned BLK_W  = 3,
    parameter int unsigned MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BLK_W-1:0]  sel_a_in,
    input  logic [BLK_W-1:0]  sel_b_in,
    input  logic [MASK_W-1:0] mask_in,
    output logic [BLK_W-1:0]  act_a,
    output logic [BLK_W-1:0]  act_b,
    output logic [MASK_W-1:0] act_mask,
    output logic [BLK_W-1:0]  eff_a,
    output logic [BLK_W-1:0]  eff_b,
    output logic [MASK_W-1:0] eff_mask
);

    typedef struct packed {
        logic [BLK_W-1:0]  sel_a;
        logic [BLK_W-1:0]  sel_b;
        logic [MASK_W-1:0] mask;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (load) begin
            bank_d.sel_a = sel_a_in;
            bank_d.sel_b = sel_b_in;
            bank_d.mask  = mask_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.sel_a <= '0;
            bank_q.sel_b <= BLK_W'(1);
            bank_q.mask  <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign act_a    = bank_q.sel_a;
    assign act_b    = bank_q.sel_b;
    assign act_mask = bank_q.mask;
    // Settings in force for the slot being entered on this edge.
    assign eff_a    = bank_d.sel_a;
    assign eff_b    = bank_d.sel_b;
    assign eff_mask = bank_d.mask;

endmodule

// File: rtl/cwc_slot_gate.sv
module cwc_slot_gate
    import cwc_pkg::*;
#(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned BLK_W = 3,
    parameter int unsigned SLOTS = 16,
    localparam int unsigned CH_W   = IDX_W + BLK_W,
    localparam int unsigned MASK_W = 2 * SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_strobe,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic              cur_live,
    input  logic [CH_W-1:0]   nxt_chan,
    input  logic              nxt_live,
    input  logic [BLK_W-1:0]  eff_a,
    input  logic [BLK_W-1:0]  eff_b,
    input  logic [MASK_W-1:0] eff_mask,
    output logic              slot_en,
    output logic              blk_end
);

    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    typedef struct packed {
        logic en;
        logic fin;
    } gate_t;

    gate_t gate_d, gate_q;

    logic [BLK_W-1:0] half_sel [2];
    logic [1:0]       half_match;
    logic [1:0]       half_bit;
    logic [BLK_W-1:0] nxt_blk;
    logic [IDX_W-1:0] nxt_idx;
    hit_e             hit;
    logic             mask_bit;

    assign nxt_blk     = nxt_chan[CH_W-1:IDX_W];
    assign nxt_idx     = nxt_chan[IDX_W-1:0];
    assign half_sel[0] = eff_a;
    assign half_sel[1] = eff_b;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [SLOTS-1:0] half_mask;
        assign half_mask     = eff_mask[h*SLOTS +: SLOTS];
        assign half_match[h] = (nxt_blk == half_sel[h]);
        assign half_bit[h]   = half_mask[nxt_idx];
    end

    always_comb begin
        hit = pick_hit(half_match[0], half_match[1]);
        unique case (hit)
            HIT_A:   mask_bit = half_bit[0];
            HIT_B:   mask_bit = half_bit[1];
            default: mask_bit = 1'b0;
        endcase
    end

    always_comb begin
        gate_d     = gate_q;
        gate_d.fin = 1'b0;
        if (word_strobe) begin
            gate_d.en  = nxt_live & mask_bit;
            gate_d.fin = cur_live & (cur_idx == LAST_IDX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign slot_en = gate_q.en;
    assign blk_end = gate_q.fin;

endmodule

// File: rtl/chan_window_ctrl.sv
module chan_window_ctrl #(
    parameter int unsigned SLOTS_PER_BLK = 16,
    parameter int unsigned NUM_BLKS      = 8,
    localparam int unsigned IDX_W  = $clog2(SLOTS_PER_BLK),
    localparam int unsigned BLK_W  = $clog2(NUM_BLKS),
    localparam int unsigned CH_W   = IDX_W + BLK_W,
    localparam int unsigned MASK_W = 2 * SLOTS_PER_BLK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_strobe,
    input  logic              frame_sync,
    input  logic [BLK_W-1:0]  blk_a_sel,
    input  logic [BLK_W-1:0]  blk_b_sel,
    input  logic [MASK_W-1:0] en_mask,
    output logic [CH_W-1:0]   cur_chan,
    output logic              frame_live,
    output logic              slot_en,
    output logic              blk_end
);

    logic [CH_W-1:0]   nxt_chan;
    logic              nxt_live;
    logic              blk_open;
    logic [BLK_W-1:0]  act_a, act_b, eff_a, eff_b;
    logic [MASK_W-1:0] act_mask, eff_mask;

    cwc_slot_counter #(.CH_W(CH_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_strobe(word_strobe),
        .frame_sync (frame_sync),
        .chan_q     (cur_chan),
        .live_q     (frame_live),
        .nxt_chan   (nxt_chan),
        .nxt_live   (nxt_live)
    );

    // A new sixteen-channel group opens on this strobe.
    assign blk_open = word_strobe & nxt_live & (nxt_chan[IDX_W-1:0] == '0);

    cwc_mask_bank #(.BLK_W(BLK_W), .MASK_W(MASK_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (blk_open),
        .sel_a_in(blk_a_sel),
        .sel_b_in(blk_b_sel),
        .mask_in (en_mask),
        .act_a   (act_a),
        .act_b   (act_b),
        .act_mask(act_mask),
        .eff_a   (eff_a),
        .eff_b   (eff_b),
        .eff_mask(eff_mask)
    );

    cwc_slot_gate #(.IDX_W(IDX_W), .BLK_W(BLK_W), .SLOTS(SLOTS_PER_BLK)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_strobe(word_strobe),
        .cur_idx    (cur_chan[IDX_W-1:0]),
        .cur_live   (frame_live),
        .nxt_chan   (nxt_chan),
        .nxt_live   (nxt_live),
        .eff_a      (eff_a),
        .eff_b      (eff_b),
        .eff_mask   (eff_mask),
        .slot_en    (slot_en),
        .blk_end    (blk_end)
    );

endmodule

// File: rtl/cwc_chk.sv
module cwc_chk #(
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned BLK_W  = 3,
    parameter int unsigned CH_W   = 7,
    parameter int unsigned MASK_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_strobe,
    input logic              frame_sync,
    input logic [CH_W-1:0]   cur_chan,
    input logic              frame_live,
    input logic              slot_en,
    input logic              blk_end,
    input logic [BLK_W-1:0]  act_a,
    input logic [BLK_W-1:0]  act_b,
    input logic [MASK_W-1:0] act_mask
);

    // R1
    sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_strobe && frame_sync |=> (cur_chan == '0) && frame_live);

    // R1
    chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_strobe && !frame_sync && frame_live && (cur_chan != '1)
        |=> frame_live && (cur_chan == $past(cur_chan) + 1'b1));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_strobe |=> $stable(cur_chan) && $stable(frame_live) && $stable(slot_en) && !blk_end);

    // R7
    end_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end |-> $past(word_strobe) && $past(frame_live) && (&$past(cur_chan[IDX_W-1:0])));

    // R7
    end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end |=> !blk_end);

    // R8
    dead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_live |-> !slot_en);

    // R6
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_strobe && (frame_sync || (frame_live && (&cur_chan[IDX_W-1:0]))))
        |=> $stable(act_mask) && $stable(act_a) && $stable(act_b));

endmodule

bind chan_window_ctrl cwc_chk #(
    .IDX_W (IDX_W),
    .BLK_W (BLK_W),
    .CH_W  (CH_W),
    .MASK_W(MASK_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_strobe(word_strobe),
    .frame_sync (frame_sync),
    .cur_chan   (cur_chan),
    .frame_live (frame_live),
    .slot_en    (slot_en),
    .blk_end    (blk_end),
    .act_a      (act_a),
    .act_b      (act_b),
    .act_mask   (act_mask)
);

// File: tb/chan_window_ctrl_bench.sv
`timescale 1ns/1ps
module chan_window_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_strobe = 1'b0;
    logic        frame_sync = 1'b0;
    logic [2:0]  blk_a_sel = 3'd0;
    logic [2:0]  blk_b_sel = 3'd1;
    logic [31:0] en_mask = 32'd0;
    logic [6:0]  cur_chan;
    logic        frame_live;
    logic        slot_en;
    logic        blk_end;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model
    logic [6:0]  m_chan = 7'd0;
    logic        m_live = 1'b0;
    logic [2:0]  m_a = 3'd0;
    logic [2:0]  m_b = 3'd1;
    logic [31:0] m_mask = 32'd0;
    logic        m_en = 1'b0;
    logic        m_end = 1'b0;

    always #2.5 clk = ~clk;

    chan_window_ctrl u_chan_window_ctrl (
        .clk(clk), .rst_n(rst_n), .word_strobe(word_strobe), .frame_sync(frame_sync),
        .blk_a_sel(blk_a_sel), .blk_b_sel(blk_b_sel), .en_mask(en_mask),
        .cur_chan(cur_chan), .frame_live(frame_live), .slot_en(slot_en), .blk_end(blk_end)
    );

    function automatic logic exp_enable(input logic [6:0] ch, input logic [2:0] a,
                                        input logic [2:0] b, input logic [31:0] m);
        if (ch[6:4] == a) return m[ch[3:0]];
        if (ch[6:4] == b) return m[16 + ch[3:0]];
        return 1'b0;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "cur_chan", {25'd0, cur_chan}, {25'd0, m_chan});
        chk(req, "frame_live", {31'd0, frame_live}, {31'd0, m_live});
        chk(req, "slot_en", {31'd0, slot_en}, {31'd0, m_en});
        chk(req, "blk_end", {31'd0, blk_end}, {31'd0, m_end});
    endtask

    // One strobed slot; outputs checked in the cycle after the strobe edge.
    task automatic slot(input logic fs, input string req);
        @(negedge clk);
        word_strobe = 1'b1;
        frame_sync  = fs;
        m_end = m_live && (m_chan[3:0] == 4'hF);
        if (fs) begin
            m_chan = 7'd0;
            m_live = 1'b1;
        end else if (m_live) begin
            if (m_chan == 7'd127) m_live = 1'b0;
            else m_chan = m_chan + 7'd1;
        end
        if (m_live && m_chan[3:0] == 4'd0) begin
            m_a = blk_a_sel; m_b = blk_b_sel; m_mask = en_mask;
        end
        m_en = m_live && exp_enable(m_chan, m_a, m_b, m_mask);
        @(negedge clk);
        word_strobe = 1'b0;
        frame_sync  = 1'b0;
        check_all(req);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        m_end = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R10 reset state
        check_all("R10");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R10");

        // R10 strobes before first sync enable nothing
        en_mask = 32'hFFFF_FFFF;
        slot(1'b0, "R10");
        slot(1'b0, "R10");

        // R1 R3 R4 R7 full frame with A=2, B=5
        blk_a_sel = 3'd2; blk_b_sel = 3'd5; en_mask = 32'hA5C3_0F71;
        slot(1'b1, "R1");
        for (int i = 1; i < 128; i++) begin
            slot(1'b0, (i % 16 == 0) ? "R7" : "R3");
        end

        // R8 run past channel 127
        slot(1'b0, "R8");
        slot(1'b0, "R8");
        slot(1'b0, "R8");

        // R2 lone frame sync ignored
        slot(1'b1, "R1");
        slot(1'b0, "R1");
        @(negedge clk); frame_sync = 1'b1;
        @(negedge clk); frame_sync = 1'b0;
        m_end = 1'b0;
        check_all("R2");
        slot(1'b0, "R2");

        // R5 both selects on block 0: half A decides
        blk_a_sel = 3'd0; blk_b_sel = 3'd0; en_mask = 32'hFFFF_0000;
        slot(1'b1, "R5");
        for (int i = 1; i < 16; i++) slot(1'b0, "R5");
        blk_a_sel = 3'd1; blk_b_sel = 3'd1; en_mask = 32'h0000_FFFF;
        for (int i = 0; i < 16; i++) slot(1'b0, "R5");

        // R6 mid-block rewrite waits for the next group
        blk_a_sel = 3'd0; blk_b_sel = 3'd1; en_mask = 32'hFFFF_FFFF;
        slot(1'b1, "R6");
        for (int i = 1; i < 4; i++) slot(1'b0, "R6");
        blk_a_sel = 3'd1; blk_b_sel = 3'd0; en_mask = 32'h0000_0000;
        for (int i = 4; i < 16; i++) slot(1'b0, "R6");
        // last slot of block 0 ended: R7 pulse on the opening of channel 16
        slot(1'b0, "R7");
        chk("R6", "slot_en new mask", {31'd0, slot_en}, 32'd0);

        // R9 hold between strobes, R7 single-cycle pulse
        en_mask = 32'hFFFF_FFFF;
        for (int i = 17; i < 32; i++) slot(1'b0, "R9");
        slot(1'b0, "R7");
        idle(1);
        check_all("R7");
        en_mask = 32'h0; blk_a_sel = 3'd7;
        idle(4);
        check_all("R9");

        // random frames
        for (int f = 0; f < 25; f++) begin
            int len;
            len = 1 + int'($urandom_range(150));
            blk_a_sel = 3'($urandom); blk_b_sel = 3'($urandom); en_mask = $urandom;
            slot(1'b1, "R1");
            for (int s = 1; s < len; s++) begin
                if ($urandom_range(9) == 0) begin
                    blk_a_sel = 3'($urandom); blk_b_sel = 3'($urandom); en_mask = $urandom;
                end
                if ($urandom_range(3) == 0) idle(int'($urandom_range(2)) + 1);
                slot(1'b0, "R3");
            end
        end

        finish_run();
    end

endmodule